// File: doc/BRIEF.md
# Tap-Selectable Shift-Register Delay Line

This block is one slice mode of a counter/PWM unit. A single-bit event input is shifted into a register as wide as the counter. Each enabled cycle the event is sampled into the top stage, and the contents move one place toward bit 0. The PWM output comes from the stages that an active tap mask selects. Setting one mask bit gives a pure delay line with a delay chosen at run time. Setting several bits makes the output the exclusive-OR of those stages.

The tap mask is programmed in two steps. Software first writes a staging copy. A separate swap strobe then moves that copy into the active mask, so a new delay takes effect on a chosen edge. Neither step touches the shift register contents. The reset input is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `tapline_delay`

## Requirements
- R1: While reset is active, and after it is released, the shift register is all zeros and `pwm_out` is low. Both the staging mask and the active mask reset to all ones. Internal reset lifts on the second rising clock edge after `rst_n` goes high.
- R2: On every rising edge with `enable` high, `event_in` is captured into stage WIDTH-1, and each stage i below it takes the old value of stage i+1.
- R3: On a rising edge with `enable` low, the shift register keeps its value, so `pwm_out` does not change unless the active mask changes.
- R4: When the active mask has only bit WIDTH-n set (1 ≤ n ≤ WIDTH), `pwm_out` equals the `event_in` value captured n enabled edges earlier, or 0 if fewer than n enabled edges have occurred since reset.
- R5: When several active mask bits are set, `pwm_out` is the exclusive-OR of all the selected stages.
- R6: An all-zero active mask holds `pwm_out` low at all times.
- R7: A rising edge with `mask_wr` high loads `mask_wdata` into the staging mask only. The active mask and `pwm_out` are not affected by that write.
- R8: A rising edge with `mask_swap` high copies the staging mask into the active mask, independent of `enable`, and leaves the shift register as it was. If `mask_wr` and `mask_swap` are high on the same edge, the active mask takes the staging value that was held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable | input | 1 | Shift enable for the delay line |
| event_in | input | 1 | Event input sampled into the top stage |
| mask_wdata | input | WIDTH | New tap mask value for the staging register |
| mask_wr | input | 1 | Write strobe for the staging mask |
| mask_swap | input | 1 | Copies the staging mask into the active mask |
| pwm_out | output | 1 | Exclusive-OR of the stages selected by the active mask |

## Verification
The assertions check on every cycle the following local behaviours:
- capture of the event into the top stage on enabled edges;
- the hold of the register when `enable` is low;
- the staging write and the swap copy;
- a low output under an all-zero mask;
- the one-cycle delay when only the top tap is active.

The exact delay for every tap position, the exclusive-OR result of multi-tap masks, the fill from zero after reset, and the old-value ordering when a write and a swap land on the same edge all depend on histories that are many cycles long. Only the bench scenarios show these. The bench runs them against a model that indexes a log of captured events.

// File: rtl/tapline_pkg.sv
package tapline_pkg;

  // Number of flops in the reset release synchroniser.
  localparam int TAPLINE_SYNC_STAGES = 2;

  // Mask programming command decoded from the strobes.
  typedef struct packed {
    logic load;
    logic swap;
  } mask_cmd_t;

endpackage

// File: rtl/tapline_rst_sync.sv
module tapline_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb sync_d = {sync_q[LAST-1:0], 1'b1};
    end else begin : g_single
      always_comb sync_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[LAST];

endmodule

// File: rtl/tapline_shifter.sv
module tapline_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] stages_q
);

  localparam int TOP = WIDTH - 1;

  logic [TOP:0] stages_d;

  // New sample enters at the top; everything moves one place down.
  always_comb begin
    stages_d = stages_q;
    if (shift_en) stages_d = {din, stages_q[TOP:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stages_q <= '0;
    else if (shift_en) stages_q <= stages_d;
  end

endmodule

// File: rtl/tapline_mask_buf.sv
module tapline_mask_buf #(
  parameter int WIDTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  tapline_pkg::mask_cmd_t cmd,
  input  logic [WIDTH-1:0]      wdata,
  output logic [WIDTH-1:0]      stage_q,
  output logic [WIDTH-1:0]      active_q
);

  localparam logic [WIDTH-1:0] MASK_RESET = '1;

  logic [WIDTH-1:0] stage_d;
  logic [WIDTH-1:0] active_d;
  logic             stage_ce;
  logic             active_ce;

  // Swap samples the staging value held before this edge's write.
  always_comb begin
    stage_ce  = cmd.load;
    active_ce = cmd.swap;
    stage_d   = cmd.load ? wdata   : stage_q;
    active_d  = cmd.swap ? stage_q : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= MASK_RESET;
    else if (stage_ce) stage_q <= stage_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active_q <= MASK_RESET;
    else if (active_ce) active_q <= active_d;
  end

endmodule

// File: rtl/tapline_tap_xor.sv
module tapline_tap_xor #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] stages,
  input  logic [WIDTH-1:0] mask,
  output logic             tap_out
);

  logic [WIDTH:0] acc;

  assign acc[0] = 1'b0;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
      assign acc[i+1] = acc[i] ^ (stages[i] & mask[i]);
    end
  endgenerate

  assign tap_out = acc[WIDTH];

endmodule

// File: rtl/tapline_delay.sv
module tapline_delay #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             event_in,
  input  logic [WIDTH-1:0] mask_wdata,
  input  logic             mask_wr,
  input  logic             mask_swap,
  output logic             pwm_out
);

  logic                   rst_core_n;
  logic [WIDTH-1:0]       shift_q;
  logic [WIDTH-1:0]       mask_buf_q;
  logic [WIDTH-1:0]       mask_act_q;
  tapline_pkg::mask_cmd_t mask_cmd;

  always_comb begin
    mask_cmd.load = mask_wr;
    mask_cmd.swap = mask_swap;
  end

  tapline_rst_sync #(
    .STAGES(tapline_pkg::TAPLINE_SYNC_STAGES)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  tapline_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .shift_en(enable),
    .din     (event_in),
    .stages_q(shift_q)
  );

  tapline_mask_buf #(.WIDTH(WIDTH)) u_mask (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cmd     (mask_cmd),
    .wdata   (mask_wdata),
    .stage_q (mask_buf_q),
    .active_q(mask_act_q)
  );

  tapline_tap_xor #(.WIDTH(WIDTH)) u_xor (
    .stages (shift_q),
    .mask   (mask_act_q),
    .tap_out(pwm_out)
  );

endmodule

// File: rtl/tapline_delay_chk.sv
module tapline_delay_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             enable,
  input logic             event_in,
  input logic [WIDTH-1:0] mask_wdata,
  input logic             mask_wr,
  input logic             mask_swap,
  input logic [WIDTH-1:0] sr_q,
  input logic [WIDTH-1:0] buf_q,
  input logic [WIDTH-1:0] act_q,
  input logic             pwm_out
);

  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  assert_capture_top_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rst_core_n && enable) |=> (sr_q[WIDTH-1] == $past(event_in)));

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rst_core_n && !enable) |=> $stable(sr_q));

  assert_top_tap_delay_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rst_core_n && enable && !mask_swap && act_q == TOP_ONLY) |=> (pwm_out == $past(event_in)));

  assert_zero_mask_low_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (act_q == '0) |-> !pwm_out);

  assert_stage_write_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rst_core_n && mask_wr) |=> (buf_q == $past(mask_wdata)));

  assert_active_kept_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rst_core_n && !mask_swap) |=> $stable(act_q));

  assert_swap_copy_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rst_core_n && mask_swap) |=> (act_q == $past(buf_q)));

endmodule

bind tapline_delay tapline_delay_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_core_n(rst_core_n),
  .enable    (enable),
  .event_in  (event_in),
  .mask_wdata(mask_wdata),
  .mask_wr   (mask_wr),
  .mask_swap (mask_swap),
  .sr_q      (shift_q),
  .buf_q     (mask_buf_q),
  .act_q     (mask_act_q),
  .pwm_out   (pwm_out)
);

// File: tb/sim_tapline_delay.sv
module sim_tapline_delay;

  localparam int W = 16;
  localparam int HIST = 8192;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         enable;
  logic         event_in;
  logic [W-1:0] mask_wdata;
  logic         mask_wr;
  logic         mask_swap;
  logic         pwm_out;

  always #5 clk = ~clk;

  tapline_delay #(.WIDTH(W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .event_in  (event_in),
    .mask_wdata(mask_wdata),
    .mask_wr   (mask_wr),
    .mask_swap (mask_swap),
    .pwm_out   (pwm_out)
  );

  int           n_cmp = 0;
  int           n_bad = 0;
  bit           hist [HIST];
  int           cnt = 0;
  logic [W-1:0] m_buf;
  logic [W-1:0] m_act;
  bit           done = 0;

  // Stage i holds the event from (W - i) enabled edges ago.
  function automatic logic stage_val(int i);
    int k;
    k = cnt - W + i;
    return (k >= 0) ? hist[k] : 1'b0;
  endfunction

  function automatic logic exp_out();
    logic r;
    r = 1'b0;
    for (int i = 0; i < W; i++) if (m_act[i]) r ^= stage_val(i);
    return r;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pwm_out=%0b expected %0b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic ev, input logic wr,
                      input logic sw, input logic [W-1:0] wd, input string tag);
    @(negedge clk);
    enable = en; event_in = ev; mask_wr = wr; mask_swap = sw; mask_wdata = wd;
    @(posedge clk);
    #1;
    if (en && cnt < HIST) begin hist[cnt] = ev; cnt++; end
    if (sw) m_act = m_buf;   // swap uses pre-write staging value
    if (wr) m_buf = wd;
    chk(tag, pwm_out, exp_out());
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] m;
    rst_n = 1'b0; enable = 1'b0; event_in = 1'b0;
    mask_wr = 1'b0; mask_swap = 1'b0; mask_wdata = '0;
    m_buf = '1; m_act = '1;
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", pwm_out, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1 after release", pwm_out, 1'b0);

    // R1: reset masks are all ones -> XOR of every stage while filling
    for (int i = 0; i < 30; i++) step(1'b1, 1'($urandom), 1'b0, 1'b0, '0, "R1");
    step(1'b1, 1'($urandom), 1'b0, 1'b1, '0, "R1 swap reset buffer");
    for (int i = 0; i < 10; i++) step(1'b1, 1'($urandom), 1'b0, 1'b0, '0, "R1");

    // R2/R4: every one-hot delay 1..W with idle gaps (R3)
    for (int n = 1; n <= W; n++) begin
      m = '0; m[W-n] = 1'b1;
      step(1'b0, 1'b0, 1'b1, 1'b0, m, "R7 write only");
      step(1'b1, 1'($urandom), 1'b0, 1'b1, '0, "R8 swap");
      for (int i = 0; i < 40; i++) begin
        logic en;
        en = ($urandom % 4) != 0;
        step(en, 1'($urandom), 1'b0, 1'b0, '0, en ? ((n == 1) ? "R2" : "R4") : "R3");
      end
    end

    // R5 multi-tap XOR; R8 write+swap on the same edge
    for (int k = 0; k < 20; k++) begin
      do m = W'($urandom); while ($countones(m) < 2);
      step(1'b1, 1'($urandom), 1'b1, 1'b1, m, "R8 same-edge write/swap");
      step(1'b1, 1'($urandom), 1'b0, 1'b1, '0, "R8 swap");
      for (int i = 0; i < 30; i++) step(1'b1, 1'($urandom), 1'b0, 1'b0, '0, "R5");
    end

    // R6 all-zero mask
    step(1'b1, 1'($urandom), 1'b1, 1'b0, '0, "R7");
    step(1'b1, 1'($urandom), 1'b0, 1'b1, '0, "R8");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0, 1'b0, '0, "R6");

    // R7 staging write leaves active (zero) mask in force
    m = '0; m[W-1] = 1'b1;
    step(1'b1, 1'b1, 1'b1, 1'b0, m, "R7");
    for (int i = 0; i < 20; i++) step(1'b1, 1'($urandom), 1'b0, 1'b0, '0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b1, '0, "R8 swap while idle");
    for (int i = 0; i < 20; i++) step(1'b1, 1'($urandom), 1'b0, 1'b0, '0, "R4");

    done = 1;
    summary();
    $finish;
  end

endmodule